// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 64 level-sensitive interrupt lines and turns them into two processor requests: a normal request and a fast request. Each line can be enabled, routed to either request and given one of 16 priority levels. A priority threshold limits which normal lines may raise the normal request. A vector word names the most urgent normal line, so a handler can read the vector, service that line and read again. It reads all-ones in the upper half once nothing eligible is left.

Software uses a 32-bit register bus with a byte address, a write strobe, write data and combinational read data. Lines 0–31 live in the "low" word of each paired register and lines 32–63 live in the "high" word. To acknowledge a level-sensitive line, software clears its enable bit. A force register lets software raise any line without hardware activity. The interrupt inputs are taken as already synchronous to the block clock.

Top module: `vec_intc`

## Requirements
- R1: After reset, enables, routing bits, priorities, force bits and the control word are all 0. The threshold reads 0x1F. Both vector words read 0xFFFF0000, and neither request is asserted.
- R2: Enables are read/write at 0x14 (lines 0–31, line n at bit n) and 0x10 (lines 32–63, line n at bit n−32). Routing uses the same layout at 0x1C/0x18, and force uses it at 0x54/0x50.
- R3: A write to 0x08 sets the enable bit of the line given by data bits [5:0]. A write to 0x0C clears it. All other enable bits keep their value, data bits [31:6] are ignored, and both addresses read 0.
- R4: The raw input levels read at 0x4C/0x48. A line is active when (raw OR force) AND enable. Normal pending (0x5C/0x58) holds active lines with routing bit 0. Fast pending (0x64/0x60) holds active lines with routing bit 1. Both follow the inputs in the same cycle.
- R5: The fast request is the OR of fast pending. The normal request is the OR of the normal pending lines that pass the threshold of R8.
- R6: Priority word x (x = 0..7) sits at 0x20 + 4·(7−x). Its nibble k is the 4-bit priority of line 8x+k.
- R7: The normal vector at 0x40 holds, in bits [31:16], the eligible normal pending line with the highest priority, with ties going to the higher line number. Bits [15:0] hold that line's priority. With no eligible line it reads 0xFFFF0000.
- R8: The threshold is a 5-bit register at 0x04, read zero-extended. A normal pending line is eligible when the threshold is 0x1F, or when its priority is strictly greater than the threshold.
- R9: The fast vector at 0x44 holds the highest-numbered fast pending line in bits [31:16], with bits [15:0] at 0. With none pending it reads 0xFFFF0000.
- R10: A write to an enable, routing, priority, force or threshold register changes the requests and vectors from the next clock cycle on. Clearing a line's enable removes that line from both requests.
- R11: The control word at 0x00 is 32-bit read/write storage. Addresses 0x68–0x7C read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 7 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_src | input | 64 | Level-sensitive interrupt lines |
| nirq_o | output | 1 | Normal interrupt request |
| firq_o | output | 1 | Fast interrupt request |

## Verification
A wrong enable, routing, force or priority bit becomes visible within one cycle of the write. It shows in the pending words, in the vector, or as a request that rises or stays low. The bench reads every register after each random step, so such an error is reported within the next sweep. A misplaced priority nibble or a bad tie-break shows up only when two competing lines are pending together. For that reason directed cases pit equal and unequal priorities against each other at both ends of the line range, and the random phase keeps several lines active at once under varying thresholds.

// File: rtl/vec_intc.sv
`timescale 1ns/1ps
module vec_intc #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [63:0]   irq_src,
  output logic          nirq_o,
  output logic          firq_o
);
  localparam int NSRC = 64;
  localparam int HALF = NSRC / 2;
  localparam int PW   = 4;
  localparam int PPW  = 32 / PW;
  localparam int IW   = $clog2(NSRC);
  localparam logic [4:0] NO_THR = 5'h1F;

  logic [31:0]     ctrl_q;
  logic [4:0]      thr_q;
  logic [NSRC-1:0] en_q, typ_q, frc_q;
  logic [PW-1:0]   prio_q [NSRC];

  wire [4:0] wa     = bus_addr[AW-1:2];
  wire [2:0] pw_idx = ~wa[2:0];
  wire       is_pri = (wa[4:3] == 2'b01);

  wire [NSRC-1:0] act   = (irq_src | frc_q) & en_q;
  wire [NSRC-1:0] npend = act & ~typ_q;
  wire [NSRC-1:0] fpend = act & typ_q;

  logic [NSRC-1:0] elig;
  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = npend[g] && (thr_q == NO_THR || {1'b0, prio_q[g]} > thr_q);
  end

  logic          nv;
  logic [IW-1:0] nwin;
  logic [PW-1:0] npr;
  always_comb begin
    nv   = 1'b0;
    nwin = '0;
    npr  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!nv || prio_q[i] >= npr)) begin
        nv   = 1'b1;
        nwin = IW'(i);
        npr  = prio_q[i];
      end
    end
  end

  logic          fv;
  logic [IW-1:0] fwin;
  always_comb begin
    fv   = 1'b0;
    fwin = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (fpend[i]) begin
        fv   = 1'b1;
        fwin = IW'(i);
      end
    end
  end

  wire [31:0] nvec = nv ? {{(16-IW){1'b0}}, nwin, {(16-PW){1'b0}}, npr} : 32'hFFFF_0000;
  wire [31:0] fvec = fv ? {{(16-IW){1'b0}}, fwin, 16'h0000} : 32'hFFFF_0000;

  assign nirq_o = |elig;
  assign firq_o = |fpend;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      thr_q  <= NO_THR;
      en_q   <= '0;
      typ_q  <= '0;
      frc_q  <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else if (bus_we) begin
      if (is_pri) begin
        for (int k = 0; k < PPW; k++) prio_q[{pw_idx, 3'(k)}] <= bus_wdata[PW*k +: PW];
      end else begin
        case (wa)
          5'h00: ctrl_q <= bus_wdata;
          5'h01: thr_q  <= bus_wdata[4:0];
          5'h02: en_q[bus_wdata[IW-1:0]] <= 1'b1;
          5'h03: en_q[bus_wdata[IW-1:0]] <= 1'b0;
          5'h04: en_q[NSRC-1:HALF]  <= bus_wdata;
          5'h05: en_q[HALF-1:0]     <= bus_wdata;
          5'h06: typ_q[NSRC-1:HALF] <= bus_wdata;
          5'h07: typ_q[HALF-1:0]    <= bus_wdata;
          5'h14: frc_q[NSRC-1:HALF] <= bus_wdata;
          5'h15: frc_q[HALF-1:0]    <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (is_pri) begin
      for (int k = 0; k < PPW; k++) bus_rdata[PW*k +: PW] = prio_q[{pw_idx, 3'(k)}];
    end else begin
      case (wa)
        5'h00: bus_rdata = ctrl_q;
        5'h01: bus_rdata = {27'd0, thr_q};
        5'h04: bus_rdata = en_q[NSRC-1:HALF];
        5'h05: bus_rdata = en_q[HALF-1:0];
        5'h06: bus_rdata = typ_q[NSRC-1:HALF];
        5'h07: bus_rdata = typ_q[HALF-1:0];
        5'h10: bus_rdata = nvec;
        5'h11: bus_rdata = fvec;
        5'h12: bus_rdata = irq_src[NSRC-1:HALF];
        5'h13: bus_rdata = irq_src[HALF-1:0];
        5'h14: bus_rdata = frc_q[NSRC-1:HALF];
        5'h15: bus_rdata = frc_q[HALF-1:0];
        5'h16: bus_rdata = npend[NSRC-1:HALF];
        5'h17: bus_rdata = npend[HALF-1:0];
        5'h18: bus_rdata = fpend[NSRC-1:HALF];
        5'h19: bus_rdata = fpend[HALF-1:0];
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (thr_q == NO_THR && en_q == '0 && !nirq_o && !firq_o));

  a_r3_set_by_num: assert property (@(posedge clk) disable iff (rst)
    (bus_we && wa == 5'h02) |=> en_q[$past(bus_wdata[IW-1:0])]);

  a_r3_clr_by_num: assert property (@(posedge clk) disable iff (rst)
    (bus_we && wa == 5'h03) |=> !en_q[$past(bus_wdata[IW-1:0])]);

  a_r7_win_is_normal: assert property (@(posedge clk) disable iff (rst)
    nirq_o |-> (en_q[nwin] && !typ_q[nwin]));

  a_r7_idle_vector: assert property (@(posedge clk) disable iff (rst)
    !nirq_o |-> (nvec[31:16] == 16'hFFFF));

  a_r8_threshold: assert property (@(posedge clk) disable iff (rst)
    (nirq_o && thr_q != NO_THR) |-> ({1'b0, prio_q[nwin]} > thr_q));

  a_r9_fast_win: assert property (@(posedge clk) disable iff (rst)
    firq_o |-> (typ_q[fwin] && en_q[fwin] && fvec[31:16] != 16'hFFFF));
endmodule

// File: tb/tb_vec_intc.sv
`timescale 1ns/1ps
module tb_vec_intc;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [6:0]  addr;
  logic        we;
  logic [31:0] wdata;
  wire  [31:0] rdata;
  logic [63:0] src;
  wire         nirq, firq;

  vec_intc dut (.clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
                .bus_rdata(rdata), .irq_src(src), .nirq_o(nirq), .firq_o(firq));

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_ctrl;
  logic [4:0]  m_thr;
  logic [63:0] m_en, m_ty, m_fr;
  logic [3:0]  m_pr [64];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_ctrl = '0; m_thr = 5'h1F; m_en = '0; m_ty = '0; m_fr = '0;
    for (int i = 0; i < 64; i++) m_pr[i] = '0;
  endtask

  function automatic logic [31:0] m_nvec();
    logic [63:0] p;
    logic f;
    int w;
    f = 1'b0; w = 0;
    p = (src | m_fr) & m_en & ~m_ty;
    for (int i = 0; i < 64; i++)
      if (p[i] && (m_thr == 5'h1F || {1'b0, m_pr[i]} > m_thr))
        if (!f || m_pr[i] >= m_pr[w]) begin f = 1'b1; w = i; end
    return f ? {16'(w), 12'd0, m_pr[w]} : 32'hFFFF_0000;
  endfunction

  function automatic logic [31:0] m_fvec();
    logic [63:0] p;
    logic [31:0] r;
    r = 32'hFFFF_0000;
    p = (src | m_fr) & m_en & m_ty;
    for (int i = 0; i < 64; i++) if (p[i]) r = {16'(i), 16'd0};
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [6:0] a);
    logic [63:0] act;
    logic [31:0] r;
    int x;
    act = (src | m_fr) & m_en;
    r = '0;
    if (a[6:5] == 2'b01) begin
      x = 7 - int'(a[4:2]);
      for (int k = 0; k < 8; k++) r[4*k +: 4] = m_pr[8*x + k];
    end else begin
      case (a[6:2])
        5'h00: r = m_ctrl;
        5'h01: r = {27'd0, m_thr};
        5'h04: r = m_en[63:32];
        5'h05: r = m_en[31:0];
        5'h06: r = m_ty[63:32];
        5'h07: r = m_ty[31:0];
        5'h10: r = m_nvec();
        5'h11: r = m_fvec();
        5'h12: r = src[63:32];
        5'h13: r = src[31:0];
        5'h14: r = m_fr[63:32];
        5'h15: r = m_fr[31:0];
        5'h16: r = act[63:32] & ~m_ty[63:32];
        5'h17: r = act[31:0] & ~m_ty[31:0];
        5'h18: r = act[63:32] & m_ty[63:32];
        5'h19: r = act[31:0] & m_ty[31:0];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(logic [6:0] a);
    if (a[6:5] == 2'b01) return "R6";
    case (a[6:2])
      5'h00: return "R11";
      5'h01: return "R8";
      5'h02, 5'h03: return "R3";
      5'h04, 5'h05, 5'h06, 5'h07, 5'h14, 5'h15: return "R2";
      5'h10: return "R7";
      5'h11: return "R9";
      5'h12, 5'h13, 5'h16, 5'h17, 5'h18, 5'h19: return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic wr(logic [6:0] a, logic [31:0] d);
    int x;
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (a[6:5] == 2'b01) begin
      x = 7 - int'(a[4:2]);
      for (int k = 0; k < 8; k++) m_pr[8*x + k] = d[4*k +: 4];
    end else begin
      case (a[6:2])
        5'h00: m_ctrl = d;
        5'h01: m_thr = d[4:0];
        5'h02: m_en[d[5:0]] = 1'b1;
        5'h03: m_en[d[5:0]] = 1'b0;
        5'h04: m_en[63:32] = d;
        5'h05: m_en[31:0] = d;
        5'h06: m_ty[63:32] = d;
        5'h07: m_ty[31:0] = d;
        5'h14: m_fr[63:32] = d;
        5'h15: m_fr[31:0] = d;
        default: ;
      endcase
    end
  endtask

  task automatic rd_exp(logic [6:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic req_chk(string tag);
    logic [31:0] nv;
    @(negedge clk);
    #1;
    nv = m_nvec();
    chk({tag, " nirq"}, {31'd0, nirq}, {31'd0, nv[31:16] != 16'hFFFF});
    chk({tag, " firq"}, {31'd0, firq}, {31'd0, |((src | m_fr) & m_en & m_ty)});
  endtask

  task automatic sweep();
    for (int a = 0; a < 128; a += 4) begin
      @(negedge clk);
      addr = 7'(a);
      #1;
      chk(tag_of(7'(a)), rdata, exp_rd(7'(a)));
    end
    req_chk("R5");
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int op;
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; we = 1'b0; addr = '0; wdata = '0; src = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    rd_exp(7'h04, 32'h0000_001F, "R1 threshold");
    rd_exp(7'h40, 32'hFFFF_0000, "R1 nvec");
    rd_exp(7'h44, 32'hFFFF_0000, "R1 fvec");
    rd_exp(7'h14, 32'h0, "R1 enable");
    rd_exp(7'h20, 32'h0, "R1 prio");
    rd_exp(7'h00, 32'h0, "R1 ctrl");
    req_chk("R1");
    sweep();

    wr(7'h08, 32'd40);
    wr(7'h08, 32'd3);
    rd_exp(7'h10, 32'h0000_0100, "R3 set high");
    rd_exp(7'h14, 32'h0000_0008, "R3 set low");
    rd_exp(7'h08, 32'h0, "R3 read zero");
    wr(7'h0C, 32'hABCD_0028);
    rd_exp(7'h10, 32'h0, "R3 clear");
    rd_exp(7'h14, 32'h0000_0008, "R3 others kept");

    wr(7'h20, 32'h5000_0000);
    wr(7'h3C, 32'h0000_0002);
    wr(7'h08, 32'd63);
    wr(7'h08, 32'd0);
    src = 64'h8000_0000_0000_0009;
    rd_exp(7'h40, 32'h003F_0005, "R6 word7 nibble7");
    rd_exp(7'h20, 32'h5000_0000, "R6 readback");
    rd_exp(7'h3C, 32'h0000_0002, "R6 word0");

    wr(7'h20, 32'h0);
    wr(7'h3C, 32'h0000_2002);
    rd_exp(7'h40, 32'h0003_0002, "R7 tie to higher");

    wr(7'h04, 32'd2);
    rd_exp(7'h40, 32'hFFFF_0000, "R8 equal not eligible");
    rd_exp(7'h5C, 32'h0000_0009, "R4 pending unmasked");
    req_chk("R8");
    wr(7'h04, 32'd1);
    rd_exp(7'h40, 32'h0003_0002, "R8 above threshold");
    wr(7'h04, 32'h1F);

    wr(7'h1C, 32'h0000_0008);
    rd_exp(7'h44, 32'h0003_0000, "R9 fast vector");
    rd_exp(7'h64, 32'h0000_0008, "R4 fast pending");
    rd_exp(7'h40, 32'h0000_0002, "R7 after reroute");
    req_chk("R9");

    wr(7'h0C, 32'd0);
    rd_exp(7'h40, 32'h003F_0000, "R10 disable drops");
    src = '0;
    rd_exp(7'h40, 32'hFFFF_0000, "R10 level gone");
    rd_exp(7'h44, 32'hFFFF_0000, "R10 fast gone");
    req_chk("R10");
    wr(7'h54, 32'h1);
    wr(7'h08, 32'd0);
    rd_exp(7'h40, 32'h0000_0002, "R4 force");

    wr(7'h68, 32'h1234_5678);
    rd_exp(7'h68, 32'h0, "R11 unmapped");
    wr(7'h00, 32'hDEAD_BEEF);
    rd_exp(7'h00, 32'hDEAD_BEEF, "R11 ctrl");
    sweep();

    for (int it = 0; it < 400; it++) begin
      op = int'($urandom % 5);
      case (op)
        0: begin
          d = ($urandom % 2) ? 32'd31 : 32'($urandom % 20);
          wr(7'h04, d);
        end
        1: begin
          @(negedge clk);
          src = {$urandom, $urandom} & {$urandom, $urandom};
        end
        2: wr(($urandom % 2) ? 7'h08 : 7'h0C, $urandom);
        3: wr(7'h20 + 7'(4 * ($urandom % 8)), $urandom);
        default: wr(7'(4 * ($urandom % 32)), $urandom);
      endcase
      sweep();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule